// File: doc/BRIEF.md
# IRIG Timecode Frame Assembler

This block sits behind a pulse-width symbol demodulator for an IRIG time code. Each cycle with `sym_valid_i` high carries one decoded symbol: a zero, a one or a position marker. The block shifts the symbols into a ten-bit window and counts them modulo 100. Two markers in a row show where a second begins. At each tenth symbol it stores two BCD digits from the window. At the end of each second it presents seconds, minutes, hours, day of year, year and the sync-indicator digit, with a one-cycle completion strobe.

Three checks are built in. The first catches a frame marker pair that arrives at an unexpected count. The second catches a decoded second that differs from the one predicted from the previous second, where the prediction steps by 1 for the fast format and by 10 for the slow format. The third catches a source status fault shown by the day or sync digits. The flags are gathered over each second and reported with its strobe. A time-valid level is high only for seconds that raised no flag.

Top module: `irig_frame_asm`

## Requirements
- R1: Symbol codes on `sym_i`: 2'b00 zero, 2'b01 one, 2'b10 position marker, 2'b11 treated as zero. Each accepted symbol shifts the window right by one. A one enters as 1 at the top bit; every other code enters as 0.
- R2: A marker accepted directly after a marker forces the symbol count to 1. If the count was not already 1, error flag bit 0 (frame error) is raised for the current second.
- R3: The symbol count runs modulo 100 and resets to 1. The symbol accepted at count 0 completes a second. `sec_done_o` is high for exactly the one cycle after that symbol is accepted, and at no other time.
- R4: At every count that is a multiple of 10, a units digit is taken from window bits [3:0] and a tens digit from bits [8:5]. At count 10 the window is first shifted right by one more bit.
- R5: Relative to the marker that starts a second (index 0), fields are sent LSB first at these indices. Seconds: units 1..4, tens 6..8. Minutes: units 10..13, tens 15..18. Hours: units 20..23, tens 25..28. Day: units 30..33, tens 35..38, hundreds 40..43. Sync digit: 55..58. Year: units 60..63, tens 65..68. Markers sit at 9, 19, ..., 99.
- R6: At each completed second the predicted second is advanced by 1 (`slow_fmt_i`=0) or by 10 (`slow_fmt_i`=1), modulo 60, from reset value 0. If it differs from the decoded second, flag bit 1 is raised. The decoded second then becomes the new prediction.
- R7: Flag bit 2 (status) is raised when the day field is 000, or when the year is nonzero and the sync digit is 0.
- R8: `err_flags_o` shows the flags gathered over the second and is updated with each strobe, and the gathered flags are then cleared. `time_valid_o` is updated at the same moment and is high exactly when those flags are all zero.
- R9: Cycles with `sym_valid_i` low have no effect, whatever `sym_i` carries.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | Symbol qualifier |
| sym_i | input | 2 | Symbol code |
| slow_fmt_i | input | 1 | Selects the 10-second prediction step |
| sec_done_o | output | 1 | Second-complete strobe |
| time_valid_o | output | 1 | Last second raised no flag |
| err_flags_o | output | 8 | Flags of the last second |
| sec_o | output | 8 | Seconds, two BCD digits |
| min_o | output | 8 | Minutes, two BCD digits |
| hour_o | output | 8 | Hours, two BCD digits |
| day_o | output | 12 | Day of year, three BCD digits |
| sync_digit_o | output | 4 | Sync-indicator digit |
| year_o | output | 8 | Year of century, two BCD digits |

## Verification
The hardest case to reach is a marker pair at the wrong count while the data that follows stays aligned. This is what separates a resynchronising frame error from a merely corrupted second. The stimulus inserts one extra marker straight after a second's closing marker. That marker pairs with the closing one at count 1 and raises no error. The real start marker then pairs with it at count 2, so the error flag is raised while every digit of that second must still decode correctly. The prediction wrap from 50 to 00 in slow format and data zeros sent as code 2'b11 are also reached deliberately.

// File: rtl/irig_fa_pkg.sv
package irig_fa_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_ONE  = 2'b01,
    SYM_MARK = 2'b10,
    SYM_RSVD = 2'b11
  } sym_e;

  localparam int ERR_W      = 8;
  localparam int ERR_FRAME  = 0;
  localparam int ERR_SECNUM = 1;
  localparam int ERR_STATUS = 2;
  localparam int NIB        = 4;
endpackage

// File: rtl/irig_fa_shifter.sv
module irig_fa_shifter
  import irig_fa_pkg::*;
#(
  parameter int SUB_BITS = 10,
  parameter int NSUB     = 10,
  localparam int PW      = $clog2(SUB_BITS),
  localparam int SW      = $clog2(NSUB)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sym_valid_i,
  input  logic [1:0]     sym_i,
  output logic           sub_end_o,
  output logic           frame_end_o,
  output logic           frame_err_o,
  output logic [SW-1:0]  slot_o,
  output logic [NIB-1:0] lo_nib_o,
  output logic [NIB-1:0] hi_nib_o
);
  logic [SUB_BITS-1:0] sh_q, sh_nxt, aligned;
  logic                last_mark_q, is_one, is_mark, mark_pair;
  logic [PW-1:0]       pos_q, pos_eff;
  logic [SW-1:0]       sub_q, sub_eff;

  always_comb begin
    is_one    = (sym_i == SYM_ONE);
    is_mark   = (sym_i == SYM_MARK);
    mark_pair = sym_valid_i && is_mark && last_mark_q;
    sh_nxt    = {is_one, sh_q[SUB_BITS-1:1]};
    pos_eff   = mark_pair ? PW'(1) : pos_q;
    sub_eff   = mark_pair ? '0 : sub_q;
    frame_err_o = mark_pair && !(pos_q == PW'(1) && sub_q == '0);
    sub_end_o   = sym_valid_i && (pos_eff == '0);
    frame_end_o = sub_end_o && (sub_eff == '0);
    // first subframe also carries the start marker in bit 0
    aligned  = (sub_eff == SW'(1)) ? (sh_nxt >> 1) : sh_nxt;
    lo_nib_o = aligned[NIB-1:0];
    hi_nib_o = aligned[2*NIB:NIB+1];
    slot_o   = (sub_eff == '0) ? SW'(NSUB-1) : sub_eff - SW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '0;
      last_mark_q <= 1'b0;
      pos_q       <= PW'(1);
      sub_q       <= '0;
    end else if (sym_valid_i) begin
      sh_q        <= sh_nxt;
      last_mark_q <= is_mark;
      if (pos_eff == PW'(SUB_BITS-1)) begin
        pos_q <= '0;
        sub_q <= (sub_eff == SW'(NSUB-1)) ? '0 : sub_eff + SW'(1);
      end else begin
        pos_q <= pos_eff + PW'(1);
        sub_q <= sub_eff;
      end
    end
  end

  assert_resync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && sym_i == SYM_MARK && last_mark_q) |=> (pos_q == PW'(2) && sub_q == '0));
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> ($stable(sh_q) && $stable(pos_q) && $stable(sub_q) && $stable(last_mark_q)));
  assert_count_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q < PW'(SUB_BITS)) && (sub_q < SW'(NSUB)));
  assert_one_top_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && sym_i == SYM_ONE) |=> sh_q[SUB_BITS-1]);
  assert_zero_top_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && sym_i != SYM_ONE) |=> !sh_q[SUB_BITS-1]);
endmodule

// File: rtl/irig_fa_digits.sv
module irig_fa_digits
  import irig_fa_pkg::*;
#(
  parameter int NSUB = 10,
  localparam int SW  = $clog2(NSUB),
  localparam int NDIG = 2 * NSUB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SW-1:0]     slot_i,
  input  logic [NIB-1:0]    lo_i,
  input  logic [NIB-1:0]    hi_i,
  output logic [NDIG*NIB-1:0] nib_o
);
  for (genvar g = 0; g < NSUB; g++) begin : g_slot
    logic [NIB-1:0] lo_q, hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (we_i && slot_i == SW'(g)) begin
        lo_q <= lo_i;
        hi_q <= hi_i;
      end
    end
    assign nib_o[(2*g)*NIB +: NIB]   = lo_q;
    assign nib_o[(2*g+1)*NIB +: NIB] = hi_q;

    assert_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && slot_i == SW'(g)) |=> (lo_q == $past(lo_i) && hi_q == $past(hi_i)));
  end
endmodule

// File: rtl/irig_fa_second.sv
module irig_fa_second
  import irig_fa_pkg::*;
#(
  parameter int NSUB      = 10,
  parameter int FAST_STEP = 1,
  parameter int SLOW_STEP = 10,
  parameter int SEC_MOD   = 60,
  localparam int NDIG     = 2 * NSUB,
  localparam int PRW      = $clog2(16 * 10)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_end_i,
  input  logic                frame_err_i,
  input  logic                slow_fmt_i,
  input  logic [NDIG*NIB-1:0] nib_i,
  output logic                sec_done_o,
  output logic                time_valid_o,
  output logic [ERR_W-1:0]    err_flags_o,
  output logic [7:0]          sec_o,
  output logic [7:0]          min_o,
  output logic [7:0]          hour_o,
  output logic [11:0]         day_o,
  output logic [3:0]          sync_digit_o,
  output logic [7:0]          year_o
);
  logic [ERR_W-1:0] acc_q, err_now;
  logic [PRW-1:0]   pred_q, pred_sum, pred_nxt, dec_sec;
  logic [7:0]       f_sec, f_min, f_hour, f_year;
  logic [11:0]      f_day;
  logic [3:0]       f_sync;
  logic             mism, status;

  function automatic logic [NIB-1:0] dig(input int k, input logic [NDIG*NIB-1:0] v);
    return v[k*NIB +: NIB];
  endfunction

  always_comb begin
    f_sec  = {dig(1, nib_i), dig(0, nib_i)};
    f_min  = {dig(3, nib_i), dig(2, nib_i)};
    f_hour = {dig(5, nib_i), dig(4, nib_i)};
    f_day  = {dig(8, nib_i), dig(7, nib_i), dig(6, nib_i)};
    f_sync = dig(11, nib_i);
    f_year = {dig(13, nib_i), dig(12, nib_i)};
    dec_sec  = PRW'(f_sec[7:4]) * PRW'(10) + PRW'(f_sec[3:0]);
    pred_sum = pred_q + (slow_fmt_i ? PRW'(SLOW_STEP) : PRW'(FAST_STEP));
    pred_nxt = (pred_sum >= PRW'(SEC_MOD)) ? pred_sum - PRW'(SEC_MOD) : pred_sum;
    mism     = (dec_sec != pred_nxt);
    status   = (f_day == '0) || (f_year != '0 && f_sync == '0);
    err_now  = acc_q;
    err_now[ERR_FRAME]  = acc_q[ERR_FRAME] | frame_err_i;
    err_now[ERR_SECNUM] = acc_q[ERR_SECNUM] | mism;
    err_now[ERR_STATUS] = acc_q[ERR_STATUS] | status;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0; pred_q <= '0; sec_done_o <= 1'b0; time_valid_o <= 1'b0;
      err_flags_o <= '0; sec_o <= '0; min_o <= '0; hour_o <= '0;
      day_o <= '0; sync_digit_o <= '0; year_o <= '0;
    end else if (frame_end_i) begin
      sec_done_o   <= 1'b1;
      err_flags_o  <= err_now;
      time_valid_o <= (err_now == '0);
      acc_q        <= '0;
      pred_q       <= dec_sec;
      sec_o <= f_sec; min_o <= f_min; hour_o <= f_hour;
      day_o <= f_day; sync_digit_o <= f_sync; year_o <= f_year;
    end else begin
      sec_done_o <= 1'b0;
      if (frame_err_i) acc_q[ERR_FRAME] <= 1'b1;
    end
  end

  assert_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> sec_done_o);
  assert_no_stray_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> !sec_done_o);
  assert_valid_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_valid_o |-> (err_flags_o == '0));
  assert_fields_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> ($stable(sec_o) && $stable(err_flags_o) && $stable(time_valid_o)));
endmodule

// File: rtl/irig_frame_asm.sv
module irig_frame_asm
  import irig_fa_pkg::*;
#(
  parameter int SUB_BITS  = 10,
  parameter int NSUB      = 10,
  parameter int FAST_STEP = 1,
  parameter int SLOW_STEP = 10,
  localparam int SW       = $clog2(NSUB),
  localparam int NDIG     = 2 * NSUB
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sym_valid_i,
  input  logic [1:0]  sym_i,
  input  logic        slow_fmt_i,
  output logic        sec_done_o,
  output logic        time_valid_o,
  output logic [7:0]  err_flags_o,
  output logic [7:0]  sec_o,
  output logic [7:0]  min_o,
  output logic [7:0]  hour_o,
  output logic [11:0] day_o,
  output logic [3:0]  sync_digit_o,
  output logic [7:0]  year_o
);
  logic                sub_end, frame_end, frame_err;
  logic [SW-1:0]       slot;
  logic [NIB-1:0]      lo_nib, hi_nib;
  logic [NDIG*NIB-1:0] nibs;

  irig_fa_shifter #(.SUB_BITS(SUB_BITS), .NSUB(NSUB)) u_shift (
    .clk_i, .rst_ni, .sym_valid_i, .sym_i,
    .sub_end_o(sub_end), .frame_end_o(frame_end), .frame_err_o(frame_err),
    .slot_o(slot), .lo_nib_o(lo_nib), .hi_nib_o(hi_nib)
  );

  irig_fa_digits #(.NSUB(NSUB)) u_digits (
    .clk_i, .rst_ni, .we_i(sub_end), .slot_i(slot),
    .lo_i(lo_nib), .hi_i(hi_nib), .nib_o(nibs)
  );

  irig_fa_second #(.NSUB(NSUB), .FAST_STEP(FAST_STEP), .SLOW_STEP(SLOW_STEP)) u_second (
    .clk_i, .rst_ni, .frame_end_i(frame_end), .frame_err_i(frame_err),
    .slow_fmt_i, .nib_i(nibs), .sec_done_o, .time_valid_o, .err_flags_o,
    .sec_o, .min_o, .hour_o, .day_o, .sync_digit_o, .year_o
  );
endmodule

// File: tb/irig_frame_asm_tb_top.sv
module irig_frame_asm_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sym_valid = 1'b0, slow_fmt = 1'b0;
  logic [1:0] sym = 2'b00;
  logic done, tvalid;
  logic [7:0] err, sec, mins, hour, year;
  logic [11:0] day;
  logic [3:0] syncd;
  int n_chk = 0, n_bad = 0;
  int pred = 0;

  typedef struct {
    logic [7:0] s, m, h, y, e;
    logic [11:0] d;
    logic [3:0] sy;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  irig_frame_asm dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sym_valid), .sym_i(sym),
    .slow_fmt_i(slow_fmt), .sec_done_o(done), .time_valid_o(tvalid),
    .err_flags_o(err), .sec_o(sec), .min_o(mins), .hour_o(hour),
    .day_o(day), .sync_digit_o(syncd), .year_o(year)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] s, input int gap);
    sym_valid = 1'b1; sym = s;
    @(negedge clk);
    sym_valid = 1'b0; sym = 2'b10; // idle garbage, must be ignored (R9)
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_second(input logic [7:0] s, m, h, input logic [11:0] d,
                             input logic [3:0] sy, input logic [7:0] y,
                             input logic [7:0] base_err, input logic [1:0] zc,
                             input int gap, input string tag);
    logic [1:0] f [100];
    exp_t e;
    int dec, step;
    for (int k = 0; k < 100; k++) f[k] = zc;
    for (int k = 0; k < 100; k++) if (k == 0 || k % 10 == 9) f[k] = 2'b10;
    for (int b = 0; b < 4; b++) begin
      f[1+b]  = s[b]    ? 2'b01 : zc;
      f[10+b] = m[b]    ? 2'b01 : zc;
      f[15+b] = m[4+b]  ? 2'b01 : zc;
      f[20+b] = h[b]    ? 2'b01 : zc;
      f[25+b] = h[4+b]  ? 2'b01 : zc;
      f[30+b] = d[b]    ? 2'b01 : zc;
      f[35+b] = d[4+b]  ? 2'b01 : zc;
      f[40+b] = d[8+b]  ? 2'b01 : zc;
      f[55+b] = sy[b]   ? 2'b01 : zc;
      f[60+b] = y[b]    ? 2'b01 : zc;
      f[65+b] = y[4+b]  ? 2'b01 : zc;
    end
    for (int b = 0; b < 3; b++) f[6+b] = s[4+b] ? 2'b01 : zc;
    step = slow_fmt ? 10 : 1;
    dec  = int'(s[7:4]) * 10 + int'(s[3:0]);
    e.s = s; e.m = m; e.h = h; e.d = d; e.sy = sy; e.y = y; e.tag = tag;
    e.e = base_err;
    if (dec != (pred + step) % 60) e.e[1] = 1'b1; // R6 prediction
    pred = dec;
    q.push_back(e);
    for (int k = 0; k < 99; k++) put(f[k], gap);
    put(f[99], 0);
    check(done === 1'b1, "R3 strobe after closing symbol", done, 1);
    @(negedge clk);
    check(done === 1'b0, "R3 strobe one cycle", done, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) check(1'b0, "R3 unexpected strobe", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(sec == e.s,   {"R5 seconds ", e.tag}, sec, e.s);
        check(mins == e.m,  {"R5 minutes ", e.tag}, mins, e.m);
        check(hour == e.h,  {"R5 hours ", e.tag}, hour, e.h);
        check(day == e.d,   {"R5 day ", e.tag}, day, e.d);
        check(syncd == e.sy,{"R5 sync digit ", e.tag}, syncd, e.sy);
        check(year == e.y,  {"R5 year ", e.tag}, year, e.y);
        check(err == e.e,   {"R8 flags ", e.tag}, err, e.e);
        check(tvalid == (e.e == 0), {"R8 time valid ", e.tag}, tvalid, e.e == 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !tvalid && err == 0 && sec == 0 && day == 0 && year == 0,
          "R10 reset outputs", {done, tvalid, err}, 0);
    put(2'b10, 0); // closing marker of a previous second
    // marker pair at count 2: frame error R2
    send_second(8'h01, 8'h23, 8'h14, 12'h123, 4'h1, 8'h24, 8'h01, 2'b00, 0, "R2 first lock");
    // zeros sent as 2'b11 (R1), clean
    send_second(8'h02, 8'h59, 8'h23, 12'h366, 4'h1, 8'h00, 8'h00, 2'b11, 0, "R1 R4 rsvd zeros");
    // idle gaps with garbage (R9)
    send_second(8'h03, 8'h00, 8'h00, 12'h001, 4'h9, 8'h00, 8'h00, 2'b00, 2, "R9 gaps");
    send_second(8'h04, 8'h10, 8'h05, 12'h000, 4'h1, 8'h00, 8'h04, 2'b00, 0, "R7 day zero");
    send_second(8'h05, 8'h10, 8'h05, 12'h200, 4'h0, 8'h25, 8'h04, 2'b00, 0, "R7 sync zero");
    send_second(8'h06, 8'h10, 8'h05, 12'h200, 4'h0, 8'h00, 8'h00, 2'b00, 0, "R7 no year");
    // extra marker: pair at count 1 is fine, next pair at count 2 flags R2
    put(2'b10, 0);
    send_second(8'h07, 8'h42, 8'h12, 12'h099, 4'h1, 8'h99, 8'h01, 2'b00, 0, "R2 resync");
    slow_fmt = 1'b1;
    send_second(8'h17, 8'h42, 8'h12, 12'h099, 4'h1, 8'h99, 8'h00, 2'b00, 0, "R6 slow step");
    send_second(8'h30, 8'h42, 8'h12, 12'h099, 4'h1, 8'h99, 8'h00, 2'b00, 0, "R6 mismatch");
    send_second(8'h40, 8'h42, 8'h12, 12'h099, 4'h1, 8'h99, 8'h00, 2'b00, 0, "R6 adopt");
    send_second(8'h50, 8'h42, 8'h12, 12'h099, 4'h1, 8'h99, 8'h00, 2'b00, 0, "R6 slow");
    send_second(8'h00, 8'h43, 8'h12, 12'h099, 4'h1, 8'h99, 8'h00, 2'b00, 0, "R6 wrap");
    slow_fmt = 1'b0;
    send_second(8'h01, 8'h43, 8'h12, 12'h099, 4'h1, 8'h99, 8'h00, 2'b00, 0, "R6 fast");
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R3 all seconds reported", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule